// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps the time of day and the calendar date in packed BCD: seconds, minutes, hours (24-hour), a weekday index, day of month, month and a two-digit year covering 2000 through 2099. A slow clock enable (`tick_en`) drives a two-stage prescaler, followed by a half-second stage. Together they produce one seconds step per `2 * PRE_LO * PRE_HI` enabled ticks. The seconds step ripples through a combinational carry chain that knows the length of every month and the leap-year rule for February.

Software-side logic writes any field of seconds or coarser through one strobe per field and a shared data byte. Counting continues during writes. A write to seconds or minutes clears the prescaler stages, so firmware can line the second boundary up with an outside event. A write to seconds also clears the read-only half-second bit. A `sync` output is raised for the final `SYNC_TICKS` ticks of every second, including the tick that causes the step. While `sync` is low, the fields can be read or written without meeting a rollover.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs read 2000-01-01, weekday 0, 00:00:00, with `half_sec` low and `sync` low.
- R2: With `tick_en` held high, seconds advance by one every `2*PRE_LO*PRE_HI` cycles. `half_sec` is low for the first `PRE_LO*PRE_HI` ticks of each second and high for the rest.
- R3: In a cycle with `tick_en` low and no write strobe, every output keeps its value.
- R4: Seconds and minutes count 00 to 59 and wrap to 00, carrying into the next field. Hours count 00 to 23, and the wrap from 23 advances the date.
- R5: The weekday counts 0 to 6. It advances with every day step and wraps from 6 to 0.
- R6: Day of month wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, and after 30 in months 04, 06, 09 and 11. The month then advances by one.
- R7: February ends on day 29 when the year value is a multiple of four (year 00 included), and on day 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R9: A field strobe loads `wr_data` into that field on the next clock, and counting continues from the loaded value. The weekday takes `wr_data[2:0]`. A write overrides an increment of the same field in the same cycle. Carries into unwritten fields still follow from the values before the write.
- R10: A write to seconds or minutes zeroes both prescaler stages, so the tick count of the current half-second restarts from zero.
- R11: `half_sec` is cleared by a seconds write and by the normal second step only. A minutes write or any other write leaves it unchanged.
- R12: `sync` is high exactly when the current position within the second, `half_sec*PRE_LO*PRE_HI + stage2*PRE_LO + stage1`, is at least `2*PRE_LO*PRE_HI - SYNC_TICKS`. It is therefore high in the cycle of every seconds step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow clock enable, one cycle per prescaler tick |
| wr_sec | input | 1 | Load seconds from `wr_data` |
| wr_min | input | 1 | Load minutes from `wr_data` |
| wr_hour | input | 1 | Load hours from `wr_data` |
| wr_wday | input | 1 | Load weekday from `wr_data[2:0]` |
| wr_mday | input | 1 | Load day of month from `wr_data` |
| wr_month | input | 1 | Load month from `wr_data` |
| wr_year | input | 1 | Load year from `wr_data` |
| wr_data | input | 8 | Shared BCD write value |
| secs | output | 8 | Seconds, BCD 00-59 |
| mins | output | 8 | Minutes, BCD 00-59 |
| hours | output | 8 | Hours, BCD 00-23 |
| wday | output | 3 | Weekday 0-6 |
| mday | output | 8 | Day of month, BCD 01-31 |
| month | output | 8 | Month, BCD 01-12 |
| year | output | 8 | Year within 2000-2099, BCD 00-99 |
| half_sec | output | 1 | High in the second half of each second |
| sync | output | 1 | Rollover window flag |

## Verification
The embedded assertions check a set of local rules on every cycle. The seconds, hours, weekday and year wraps land on their base values. A leap-year February moves from day 28 to 29. Idle cycles leave the prescaler and fields untouched. A seconds or minutes write zeroes the prescaler, and a written hour appears on the next clock. `sync` is high whenever a seconds step fires. Month lengths for all twelve months across all hundred years, a write that meets an increment in the same cycle, and the exact spacing of steps after a prescaler clear are shown only by the bench. Its integer calendar model sweeps every month of every year and compares every output after every cycle.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] month;
    logic [7:0] mday;
    logic [2:0] wday;
    logic [7:0] hours;
    logic [7:0] mins;
    logic [7:0] secs;
  } cal_t;

  localparam int WI_SEC   = 0;
  localparam int WI_MIN   = 1;
  localparam int WI_HOUR  = 2;
  localparam int WI_WDAY  = 3;
  localparam int WI_MDAY  = 4;
  localparam int WI_MONTH = 5;
  localparam int WI_YEAR  = 6;
  localparam int N_WR     = 7;

  // add one to a two-digit BCD value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // wrap to base at top, otherwise add one
  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] top,
                                          input logic [7:0] base);
    return (v == top) ? base : bcd_inc(v);
  endfunction

  // divisible by four: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic leap_yr(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_yr(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/bcd_cal_prescaler.sv
module bcd_cal_prescaler #(
  parameter int PRE_LO     = 128,
  parameter int PRE_HI     = 128,
  parameter int SYNC_TICKS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic clr_pre,
  input  logic clr_half,
  output logic half_sec,
  output logic sync,
  output logic sec_step
);
  localparam int HALF    = PRE_LO * PRE_HI;
  localparam int PER_SEC = 2 * HALF;
  localparam int LO_W    = (PRE_LO > 2) ? $clog2(PRE_LO) : 1;
  localparam int HI_W    = (PRE_HI > 2) ? $clog2(PRE_HI) : 1;
  localparam int POS_W   = $clog2(PER_SEC + 1);

  logic [LO_W-1:0]  lo;
  logic [HI_W-1:0]  hi;
  logic             half_q;
  logic             lo_wrap, hi_wrap;
  logic [POS_W-1:0] pos;

  // internal events, named for the assertions
  assign lo_wrap  = tick_en && (lo == LO_W'(PRE_LO - 1));
  assign hi_wrap  = lo_wrap && (hi == HI_W'(PRE_HI - 1));
  assign sec_step = hi_wrap && half_q;

  always_comb begin
    pos  = (half_q ? POS_W'(HALF) : '0) + POS_W'(hi) * POS_W'(PRE_LO) + POS_W'(lo);
    sync = (pos >= POS_W'(PER_SEC - SYNC_TICKS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo     <= '0;
      hi     <= '0;
      half_q <= 1'b0;
    end else begin
      if (clr_pre)       lo <= '0;
      else if (tick_en)  lo <= lo_wrap ? '0 : lo + LO_W'(1);
      if (clr_pre)       hi <= '0;
      else if (lo_wrap)  hi <= hi_wrap ? '0 : hi + HI_W'(1);
      if (clr_half)      half_q <= 1'b0;
      else if (hi_wrap)  half_q <= ~half_q;
    end
  end

  assign half_sec = half_q;

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pre |=> (lo == '0) && (hi == '0)); // R10
  AST_HALF_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_half |=> !half_sec); // R11
  AST_HALF_ONLY_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_half && !hi_wrap) |=> $stable(half_sec)); // R11
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !clr_pre && !clr_half) |=> $stable({lo, hi, half_q})); // R3
  AST_SYNC_AT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |-> sync); // R12
endmodule

// File: rtl/bcd_cal_fields.sv
module bcd_cal_fields
  import bcd_cal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sec_step,
  input  logic [N_WR-1:0] wr_sel,
  input  logic [7:0]      wr_data,
  output cal_t            now
);
  cal_t nxt;
  logic sec_wrap, min_wrap, day_step, day_wrap, mon_wrap;

  // carry chain, named for the assertions
  assign sec_wrap = sec_step && (now.secs  == 8'h59);
  assign min_wrap = sec_wrap && (now.mins  == 8'h59);
  assign day_step = min_wrap && (now.hours == 8'h23);
  assign day_wrap = day_step && (now.mday  == last_day(now.month, now.year));
  assign mon_wrap = day_wrap && (now.month == 8'h12);

  always_comb begin
    nxt = now;
    if (sec_step) nxt.secs  = bcd_step(now.secs,  8'h59, 8'h00);
    if (sec_wrap) nxt.mins  = bcd_step(now.mins,  8'h59, 8'h00);
    if (min_wrap) nxt.hours = bcd_step(now.hours, 8'h23, 8'h00);
    if (day_step) begin
      nxt.wday = (now.wday == 3'd6) ? 3'd0 : now.wday + 3'd1;
      nxt.mday = day_wrap ? 8'h01 : bcd_inc(now.mday);
    end
    if (day_wrap) nxt.month = bcd_step(now.month, 8'h12, 8'h01);
    if (mon_wrap) nxt.year  = bcd_step(now.year,  8'h99, 8'h00);
    // a write replaces the value of its own field only
    if (wr_sel[WI_SEC])   nxt.secs  = wr_data;
    if (wr_sel[WI_MIN])   nxt.mins  = wr_data;
    if (wr_sel[WI_HOUR])  nxt.hours = wr_data;
    if (wr_sel[WI_WDAY])  nxt.wday  = wr_data[2:0];
    if (wr_sel[WI_MDAY])  nxt.mday  = wr_data;
    if (wr_sel[WI_MONTH]) nxt.month = wr_data;
    if (wr_sel[WI_YEAR])  nxt.year  = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now <= '{year: 8'h00, month: 8'h01, mday: 8'h01, wday: 3'd0,
               hours: 8'h00, mins: 8'h00, secs: 8'h00};
    end else begin
      now <= nxt;
    end
  end

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_wrap && !wr_sel[WI_SEC]) |=> (now.secs == 8'h00)); // R4
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_sel[WI_HOUR]) |=> (now.hours == 8'h00)); // R4
  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && now.wday == 3'd6 && !wr_sel[WI_WDAY]) |=> (now.wday == 3'd0)); // R5
  AST_FEB_LEAP: assert property (@(posedge clk) disable iff (!rst_n)
    (day_step && !wr_sel[WI_MDAY] && now.month == 8'h02 && now.mday == 8'h28
     && now.year[1:0] == 2'b00 && !now.year[4]) |=> (now.mday == 8'h29)); // R7
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_wrap && now.year == 8'h99 && !wr_sel[WI_YEAR]) |=> (now.year == 8'h00)); // R8
  AST_WR_HOUR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[WI_HOUR] |=> (now.hours == $past(wr_data))); // R9
  AST_FIELDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_step && wr_sel == '0) |=> $stable(now)); // R3
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcd_cal_pkg::*;
#(
  parameter int PRE_LO     = 128,
  parameter int PRE_HI     = 128,
  parameter int SYNC_TICKS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_sec,
  input  logic       wr_min,
  input  logic       wr_hour,
  input  logic       wr_wday,
  input  logic       wr_mday,
  input  logic       wr_month,
  input  logic       wr_year,
  input  logic [7:0] wr_data,
  output logic [7:0] secs,
  output logic [7:0] mins,
  output logic [7:0] hours,
  output logic [2:0] wday,
  output logic [7:0] mday,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic       half_sec,
  output logic       sync
);
  logic [N_WR-1:0] wr_sel;
  logic            sec_step;
  cal_t            now;

  assign wr_sel = {wr_year, wr_month, wr_mday, wr_wday, wr_hour, wr_min, wr_sec};

  bcd_cal_prescaler #(
    .PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .SYNC_TICKS(SYNC_TICKS)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .clr_pre  (wr_sec | wr_min),
    .clr_half (wr_sec),
    .half_sec (half_sec),
    .sync     (sync),
    .sec_step (sec_step)
  );

  bcd_cal_fields u_fields (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_step (sec_step),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .now      (now)
  );

  assign secs  = now.secs;
  assign mins  = now.mins;
  assign hours = now.hours;
  assign wday  = now.wday;
  assign mday  = now.mday;
  assign month = now.month;
  assign year  = now.year;

  AST_STEP_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (secs != $past(secs) && !$past(wr_sec)) |-> $past(sync)); // R12
endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  localparam int PL = 2, PH = 2, ST = 3;
  localparam int TPH = PL * PH;

  logic clk = 0, rst_n = 0, tick_en = 0;
  logic [6:0] wr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] secs, mins, hours, mday, month, year;
  logic [2:0] wday;
  logic half_sec, sync;

  always #2 clk = ~clk;

  bcd_calendar #(.PRE_LO(PL), .PRE_HI(PH), .SYNC_TICKS(ST)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_sec(wr[0]), .wr_min(wr[1]), .wr_hour(wr[2]), .wr_wday(wr[3]),
    .wr_mday(wr[4]), .wr_month(wr[5]), .wr_year(wr[6]), .wr_data(wr_data),
    .secs(secs), .mins(mins), .hours(hours), .wday(wday), .mday(mday),
    .month(month), .year(year), .half_sec(half_sec), .sync(sync));

  int vecs = 0, fails = 0;
  bit done = 0;
  int m_sec = 0, m_min = 0, m_hr = 0, m_wd = 0, m_day = 1, m_mon = 1, m_yr = 0;
  int m_pre = 0, m_half = 0;

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int unbcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic fld(input string tag, input string nm, input int act, input int exp_v,
                     inout bit bad);
    if (act != exp_v) begin
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp_v);
      bad = 1;
    end
  endtask

  task automatic check_all(input string tag);
    bit bad = 0;
    vecs++;
    fld(tag, "secs", secs, bcd(m_sec), bad);
    fld(tag, "mins", mins, bcd(m_min), bad);
    fld(tag, "hours", hours, bcd(m_hr), bad);
    fld(tag, "wday", wday, m_wd, bad);
    fld(tag, "mday", mday, bcd(m_day), bad);
    fld(tag, "month", month, bcd(m_mon), bad);
    fld(tag, "year", year, bcd(m_yr), bad);
    fld(tag, "half_sec", half_sec, m_half, bad);
    fld("R12", "sync", sync, int'((m_half * TPH + m_pre) >= 2 * TPH - ST), bad);
    if (bad) fails++;
  endtask

  task automatic adv_sec();
    m_sec++;
    if (m_sec == 60) begin
      m_sec = 0; m_min++;
      if (m_min == 60) begin
        m_min = 0; m_hr++;
        if (m_hr == 24) begin
          m_hr = 0; m_wd = (m_wd + 1) % 7; m_day++;
          if (m_day > dim(m_mon, m_yr)) begin
            m_day = 1; m_mon++;
            if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  // one clock: drive, clock, update model (tick first, writes override), compare
  task automatic cyc(input bit te, input logic [6:0] w, input logic [7:0] d, input string tag);
    tick_en = te; wr = w; wr_data = d;
    @(posedge clk); #1;
    if (te) begin
      if (m_pre == TPH - 1) begin
        m_pre = 0;
        if (m_half == 1) begin m_half = 0; adv_sec(); end
        else m_half = 1;
      end else m_pre++;
    end
    if (w[0]) begin m_sec = unbcd(d); m_pre = 0; m_half = 0; end
    if (w[1]) begin m_min = unbcd(d); m_pre = 0; end
    if (w[2]) m_hr  = unbcd(d);
    if (w[3]) m_wd  = int'(d[2:0]);
    if (w[4]) m_day = unbcd(d);
    if (w[5]) m_mon = unbcd(d);
    if (w[6]) m_yr  = unbcd(d);
    tick_en = 0; wr = '0;
    check_all(tag);
  endtask

  task automatic set_date(input int y, input int mo, input int d, input int wd,
                          input int h, input int mi, input int s, input string tag);
    cyc(0, 7'h40, bcd(y), tag);
    cyc(0, 7'h20, bcd(mo), tag);
    cyc(0, 7'h10, bcd(d), tag);
    cyc(0, 7'h08, 8'(wd), tag);
    cyc(0, 7'h04, bcd(h), tag);
    cyc(0, 7'h02, bcd(mi), tag);
    cyc(0, 7'h01, bcd(s), tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, '0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check_all("R1");
    run(3 * 2 * TPH, "R2");
    for (int i = 0; i < 6; i++) cyc(0, '0, '0, "R3");
    for (int i = 0; i < 30; i++) cyc((i % 3) != 0, '0, '0, "R2");
    // minute and hour carries over a long run
    set_date(10, 5, 14, 2, 0, 58, 50, "R4");
    run(15 * 2 * TPH, "R4");
    set_date(10, 5, 14, 2, 23, 59, 58, "R4");
    run(3 * 2 * TPH, "R4");
    // weekday wrap
    set_date(10, 5, 14, 6, 23, 59, 59, "R5");
    run(2 * TPH + 1, "R5");
    // every month end of every year
    for (int y = 0; y < 100; y++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        string tg;
        tg = (mo == 2) ? "R7" : (mo == 12) ? "R8" : "R6";
        set_date(y, mo, dim(mo, y), (y + mo) % 7, 23, 59, 59, tg);
        run(2 * TPH + 1, tg);
      end
      set_date(y, 2, 28, 3, 23, 59, 59, "R7");
      run(2 * TPH + 1, "R7");
    end
    // write during counting; write meets increment in the same cycle
    set_date(20, 7, 31, 4, 23, 59, 59, "R9");
    run(2 * TPH - 1, "R9");
    cyc(1, 7'h01, 8'h30, "R9");
    run(3, "R9");
    cyc(1, 7'h04, 8'h07, "R9");
    run(2 * TPH, "R9");
    cyc(1, 7'h10, 8'h09, "R9");
    run(2 * TPH, "R9");
    // prescaler clear from minutes write while half_sec is high
    run(TPH + 1, "R10");
    cyc(1, 7'h02, 8'h44, "R11");
    run(3 * 2 * TPH, "R10");
    // seconds write while half_sec high clears it
    run(TPH + 2, "R11");
    cyc(1, 7'h01, 8'h12, "R11");
    run(2 * TPH + 2, "R11");
    // other writes leave half_sec alone
    run(TPH + 1, "R11");
    cyc(0, 7'h20, 8'h03, "R11");
    cyc(0, 7'h40, 8'h55, "R11");
    run(2 * TPH, "R12");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule